// File: doc/BRIEF.md
# Peripheral Register Access Guard

This block sits between the register bus and a group of fourteen security-sensitive peripherals. Each access that reaches it carries the index of the target peripheral, a direction (read or write) and a privilege flag. The guard decides whether the access passes through to the peripheral or is stopped. Protection is held in one 32-bit protection word. Each peripheral has a read-protect bit and a write-protect bit in that word. One error-select bit in the same word chooses how a stopped access is answered: either it is dropped without a signal, or it is also answered with a bus error. Privileged accesses are never stopped.

The protection word is guarded by a key register. A two-state machine tracks the key. `KEY_SHUT` is the reset state. Writing the unlock key to the key register takes the machine to `KEY_OPEN` (transition UNLOCK). Writing any other value returns it to `KEY_SHUT` (transition RELOCK). Writing the key register while already in a state is allowed and follows the same rule: the unlock key keeps or enters `KEY_OPEN`, and any other value keeps or enters `KEY_SHUT`. The protection word can only be written while the machine is in `KEY_OPEN`.

Peripheral index `i` (0..13) owns its read-protect bit at position `2*i` when `i < 5`, and at `2*i + 2` when `i >= 5`. Positions 10 and 11 are therefore skipped. Its write-protect bit is the next bit up. Bit 31 is the error-select bit.

Top module: `periph_access_guard`

## Requirements
- R1: After reset, the protection word reads 0, the key machine is in `KEY_SHUT` (`unlocked_o` = 0), and every access passes.
- R2: A write with `cfg_addr` = 0 is a key write. If `cfg_wdata[15:0]` equals 16'h5AC3, the machine enters `KEY_OPEN`, and `unlocked_o` = 1 from the next cycle. Any other value puts it in `KEY_SHUT`, and `unlocked_o` = 0 from the next cycle.
- R3: A write with `cfg_addr` = 1 while in `KEY_SHUT` leaves `prot_o` unchanged.
- R4: A write with `cfg_addr` = 1 while in `KEY_OPEN` updates `prot_o` on the next cycle. Only the legal positions are stored: the read-protect bits, the write-protect bits and bit 31. All other bits read 0, so writing all ones reads back 32'hBFFFF3FF.
- R5: An unprivileged read of a peripheral whose read-protect bit is set is blocked. `acc_block_o` = 1, `per_sel_o` = 0 and `acc_rdata_o` = 0.
- R6: An unprivileged write of a peripheral whose write-protect bit is set is blocked. `acc_block_o` = 1, and neither `per_sel_o` nor `per_we_o` is raised.
- R7: The read-protect and write-protect bits act independently. A read-protect bit alone never blocks a write, and a write-protect bit alone never blocks a read. Each bit affects only its own peripheral.
- R8: An access with `acc_priv` = 1 is never blocked, whatever the protection word holds.
- R9: `acc_err_o` = 1 exactly when an access is blocked and bit 31 of the protection word is 1. When bit 31 is 0, a blocked access is dropped silently (`acc_err_o` = 0).
- R10: Indices 14 and 15 are unguarded and always pass.
- R11: An access that passes raises `per_sel_o` in the same cycle. `per_we_o` is raised for a write, and `acc_rdata_o` equals `per_rdata_i` for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Configuration target: 0 = key register, 1 = protection word |
| cfg_wdata | input | 32 | Configuration write data |
| prot_o | output | 32 | Current protection word |
| unlocked_o | output | 1 | 1 while the key machine is in `KEY_OPEN` |
| acc_valid | input | 1 | Access request present |
| acc_idx | input | 4 | Target peripheral index |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged access |
| per_sel_o | output | 1 | Access forwarded to the peripheral |
| per_we_o | output | 1 | Write strobe toward the peripheral |
| per_rdata_i | input | 32 | Read data returned by the peripheral |
| acc_rdata_o | output | 32 | Read data returned to the requester |
| acc_block_o | output | 1 | Access was stopped |
| acc_err_o | output | 1 | Bus error response for a stopped access |

## Verification
The assertions take for granted that `cfg_addr` and `cfg_wdata` are stable whenever `cfg_we` is high. They also assume that access inputs are settled before an edge, because the pass/block decision is purely combinational. The stimulus drives every input at the falling clock edge and checks the decision a short time later. It never issues a configuration write and an access that depends on it in the same cycle, so each check sees a protection word that has already settled. Request fields are only given meaning while `acc_valid` is high, and the bench returns `acc_valid` to 0 after every access.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

    typedef enum logic {
        KEY_SHUT = 1'b0,
        KEY_OPEN = 1'b1
    } key_state_e;

    // Bit position of the read-protect bit for peripheral idx.
    // The word leaves a two-bit hole after the first `gap` peripherals.
    function automatic int unsigned rp_pos(input int unsigned idx, input int unsigned gap);
        return (idx < gap) ? 2 * idx : 2 * idx + 2;
    endfunction

    // All storable bits: read/write-protect pairs plus the error-select bit.
    function automatic logic [31:0] legal_mask(input int unsigned n, input int unsigned gap,
                                               input int unsigned errbit);
        logic [31:0] m;
        m = '0;
        for (int unsigned k = 0; k < n; k++) begin
            m[rp_pos(k, gap)]     = 1'b1;
            m[rp_pos(k, gap) + 1] = 1'b1;
        end
        m[errbit] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pag_key_fsm.sv
module pag_key_fsm
    import acc_guard_pkg::*;
#(
    parameter int unsigned KEY_W      = 16,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h5AC3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_data,
    output logic             open_o
);

    key_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_SHUT: if (key_we && key_data == UNLOCK_KEY) state_d = KEY_OPEN;  // UNLOCK
            KEY_OPEN: if (key_we && key_data != UNLOCK_KEY) state_d = KEY_SHUT;  // RELOCK
            default:  state_d = KEY_SHUT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            KEY_OPEN: open_o = 1'b1;
            default:  open_o = 1'b0;
        endcase
    end

    // R2
    wrong_key_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_we && key_data != UNLOCK_KEY |=> !open_o);

    // R2
    right_key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_we && key_data == UNLOCK_KEY |=> open_o);

endmodule

// File: rtl/pag_prot_reg.sv
module pag_prot_reg
    import acc_guard_pkg::*;
#(
    parameter int unsigned N_PERIPH = 14,
    parameter int unsigned GAP_AFTER = 5,
    parameter int unsigned ERR_BIT   = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        open_i,
    input  logic        wr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] prot_o
);

    localparam logic [31:0] LEGAL = legal_mask(N_PERIPH, GAP_AFTER, ERR_BIT);

    logic [31:0] prot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              prot_q <= '0;
        else if (wr_i && open_i) prot_q <= wdata_i & LEGAL;
    end

    assign prot_o = prot_q;

    // R3
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> $stable(prot_o));

    // R4
    no_stray_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_o & ~LEGAL) == 32'd0);

endmodule

// File: rtl/pag_access_judge.sv
module pag_access_judge
    import acc_guard_pkg::*;
#(
    parameter int unsigned N_PERIPH  = 14,
    parameter int unsigned GAP_AFTER = 5,
    parameter int unsigned ERR_BIT   = 31,
    parameter int unsigned IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      prot_i,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             acc_write,
    input  logic             acc_priv,
    input  logic [31:0]      per_rdata_i,
    output logic             per_sel_o,
    output logic             per_we_o,
    output logic [31:0]      acc_rdata_o,
    output logic             acc_block_o,
    output logic             acc_err_o
);

    localparam int unsigned SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0] rd_lock, wr_lock;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < N_PERIPH) begin : g_guarded
            assign rd_lock[g] = prot_i[rp_pos(g, GAP_AFTER)];
            assign wr_lock[g] = prot_i[rp_pos(g, GAP_AFTER) + 1];
        end else begin : g_open
            assign rd_lock[g] = 1'b0;
            assign wr_lock[g] = 1'b0;
        end
    end

    logic hit;

    always_comb begin
        hit         = acc_valid && !acc_priv && (acc_write ? wr_lock[acc_idx] : rd_lock[acc_idx]);
        acc_block_o = hit;
        acc_err_o   = hit && prot_i[ERR_BIT];
        per_sel_o   = acc_valid && !hit;
        per_we_o    = per_sel_o && acc_write;
        acc_rdata_o = (per_sel_o && !acc_write) ? per_rdata_i : 32'd0;
    end

    // R8
    priv_never_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_priv |-> !acc_block_o);

    // R9
    err_only_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err_o |-> acc_block_o && prot_i[ERR_BIT]);

    // R6
    no_strobe_on_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_block_o |-> !per_sel_o && !per_we_o);

    // R5
    blocked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_block_o && !acc_write |-> acc_rdata_o == 32'd0);

    // R10
    unguarded_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_idx >= IDX_W'(N_PERIPH) |-> per_sel_o);

endmodule

// File: rtl/periph_access_guard.sv
module periph_access_guard
    import acc_guard_pkg::*;
#(
    parameter int unsigned N_PERIPH   = 14,
    parameter int unsigned GAP_AFTER  = 5,
    parameter int unsigned ERR_BIT    = 31,
    parameter logic [15:0] UNLOCK_KEY = 16'h5AC3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] prot_o,
    output logic        unlocked_o,
    input  logic        acc_valid,
    input  logic [3:0]  acc_idx,
    input  logic        acc_write,
    input  logic        acc_priv,
    output logic        per_sel_o,
    output logic        per_we_o,
    input  logic [31:0] per_rdata_i,
    output logic [31:0] acc_rdata_o,
    output logic        acc_block_o,
    output logic        acc_err_o
);

    localparam int unsigned IDX_W = 4;

    logic open_w;

    pag_key_fsm #(.KEY_W(16), .UNLOCK_KEY(UNLOCK_KEY)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (cfg_we && !cfg_addr),
        .key_data (cfg_wdata[15:0]),
        .open_o   (open_w)
    );

    pag_prot_reg #(.N_PERIPH(N_PERIPH), .GAP_AFTER(GAP_AFTER), .ERR_BIT(ERR_BIT)) u_prot (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_i  (open_w),
        .wr_i    (cfg_we && cfg_addr),
        .wdata_i (cfg_wdata),
        .prot_o  (prot_o)
    );

    pag_access_judge #(.N_PERIPH(N_PERIPH), .GAP_AFTER(GAP_AFTER), .ERR_BIT(ERR_BIT),
                       .IDX_W(IDX_W)) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .prot_i      (prot_o),
        .acc_valid   (acc_valid),
        .acc_idx     (acc_idx),
        .acc_write   (acc_write),
        .acc_priv    (acc_priv),
        .per_rdata_i (per_rdata_i),
        .per_sel_o   (per_sel_o),
        .per_we_o    (per_we_o),
        .acc_rdata_o (acc_rdata_o),
        .acc_block_o (acc_block_o),
        .acc_err_o   (acc_err_o)
    );

    assign unlocked_o = open_w;

endmodule

// File: tb/periph_access_guard_bench.sv
module periph_access_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] prot_o;
    logic        unlocked_o;
    logic        acc_valid = 1'b0;
    logic [3:0]  acc_idx = '0;
    logic        acc_write = 1'b0;
    logic        acc_priv = 1'b0;
    logic        per_sel_o, per_we_o, acc_block_o, acc_err_o;
    logic [31:0] per_rdata_i = '0;
    logic [31:0] acc_rdata_o;

    int n_cmp = 0;
    int n_bad = 0;

    periph_access_guard u_periph_access_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .prot_o(prot_o), .unlocked_o(unlocked_o), .acc_valid(acc_valid), .acc_idx(acc_idx),
        .acc_write(acc_write), .acc_priv(acc_priv), .per_sel_o(per_sel_o), .per_we_o(per_we_o),
        .per_rdata_i(per_rdata_i), .acc_rdata_o(acc_rdata_o), .acc_block_o(acc_block_o),
        .acc_err_o(acc_err_o)
    );

    always #10 clk = ~clk;

    function automatic int rd_bit(input int i);
        return (i < 5) ? 2 * i : 2 * i + 2;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        #2;
    endtask

    task automatic set_prot(input logic [31:0] d);
        cfg_write(1'b0, 32'h0000_5AC3);
        cfg_write(1'b1, d);
    endtask

    // drives one access, returns {block, err, sel, we} and read data
    task automatic access(input int idx, input logic wr, input logic pv,
                          output logic [3:0] flags, output logic [31:0] rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = 4'(idx); acc_write = wr; acc_priv = pv;
        per_rdata_i = 32'hC0DE_0000 | 32'(idx);
        #2;
        flags = {acc_block_o, acc_err_o, per_sel_o, per_we_o};
        rd = acc_rdata_o;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [3:0] f; logic [31:0] rd;
        chk("R1 prot", prot_o, 32'd0);
        chk("R1 unlocked", 32'(unlocked_o), 32'd0);
        access(3, 1'b0, 1'b0, f, rd);
        chk("R1 read passes", 32'(f), 32'b0010);
    endtask

    task automatic t_key();
        cfg_write(1'b0, 32'h0000_1234);
        chk("R2 wrong key", 32'(unlocked_o), 32'd0);
        cfg_write(1'b1, 32'hFFFF_FFFF);
        chk("R3 locked write ignored", prot_o, 32'd0);
        cfg_write(1'b0, 32'hFFFF_5AC3);
        chk("R2 unlock", 32'(unlocked_o), 32'd1);
        cfg_write(1'b0, 32'h0000_5AC2);
        chk("R2 relock", 32'(unlocked_o), 32'd0);
        cfg_write(1'b1, 32'h0000_0001);
        chk("R3 relocked write ignored", prot_o, 32'd0);
    endtask

    task automatic t_prot_write();
        set_prot(32'hFFFF_FFFF);
        chk("R4 legal bits", prot_o, 32'hBFFF_F3FF);
        chk("R4 stays unlocked", 32'(unlocked_o), 32'd1);
        set_prot(32'h0000_0C00);
        chk("R4 hole bits", prot_o, 32'd0);
    endtask

    task automatic t_single_read_bit();
        logic [3:0] f; logic [31:0] rd;
        for (int i = 0; i < 14; i++) begin
            set_prot(32'd1 << rd_bit(i));
            for (int j = 0; j < 14; j++) begin
                access(j, 1'b0, 1'b0, f, rd);
                chk((i == j) ? "R5 read blocked" : "R7 other read passes", 32'(f),
                    (i == j) ? 32'b1000 : 32'b0010);
                chk("R5 read data", rd, (i == j) ? 32'd0 : (32'hC0DE_0000 | 32'(j)));
            end
            access(i, 1'b1, 1'b0, f, rd);
            chk("R7 write unaffected by read bit", 32'(f), 32'b0011);
        end
    endtask

    task automatic t_single_write_bit();
        logic [3:0] f; logic [31:0] rd;
        for (int i = 0; i < 14; i++) begin
            set_prot(32'd1 << (rd_bit(i) + 1));
            for (int j = 0; j < 14; j++) begin
                access(j, 1'b1, 1'b0, f, rd);
                chk((i == j) ? "R6 write blocked" : "R7 other write passes", 32'(f),
                    (i == j) ? 32'b1000 : 32'b0011);
            end
            access(i, 1'b0, 1'b0, f, rd);
            chk("R7 read unaffected by write bit", 32'(f), 32'b0010);
            chk("R11 read data forwarded", rd, 32'hC0DE_0000 | 32'(i));
        end
    endtask

    task automatic t_priv_and_err();
        logic [3:0] f; logic [31:0] rd;
        set_prot(32'h3FFF_F3FF);
        access(9, 1'b0, 1'b1, f, rd);
        chk("R8 priv read", 32'(f), 32'b0010);
        access(9, 1'b1, 1'b1, f, rd);
        chk("R8 priv write", 32'(f), 32'b0011);
        access(4, 1'b1, 1'b0, f, rd);
        chk("R9 silent drop", 32'(f), 32'b1000);
        set_prot(32'hBFFF_F3FF);
        access(4, 1'b1, 1'b0, f, rd);
        chk("R9 bus error write", 32'(f), 32'b1100);
        access(13, 1'b0, 1'b0, f, rd);
        chk("R9 bus error read", 32'(f), 32'b1100);
        access(13, 1'b0, 1'b1, f, rd);
        chk("R8 priv no error", 32'(f), 32'b0010);
        for (int k = 14; k < 16; k++) begin
            access(k, 1'b0, 1'b0, f, rd);
            chk("R10 unguarded read", 32'(f), 32'b0010);
            access(k, 1'b1, 1'b0, f, rd);
            chk("R10 unguarded write", 32'(f), 32'b0011);
        end
    endtask

    task automatic t_idle();
        @(negedge clk);
        #2;
        chk("R11 idle no select", 32'({per_sel_o, per_we_o, acc_block_o, acc_err_o}), 32'd0);
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_key();
        t_prot_write();
        t_single_read_bit();
        t_single_write_bit();
        t_priv_and_err();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule